// File: doc/BRIEF.md
# Nonzero Element Compactor

This block receives a vector of eight 8-bit elements and, within a single clock, moves every nonzero element down to the lowest slot indices. The nonzero elements keep their relative order. Every slot above the last packed element is filled with zero. Along with the packed vector, the block reports how many of the inputs were nonzero.

A companion stage drives a vector together with an input-valid strobe. One clock later the packed vector, the nonzero count and an output-valid strobe appear on registered outputs. New vectors may be presented on every clock.

Inside, a prefix count over the nonzero flags gives each input its destination rank. Each output slot has its own selector, which picks the single input whose rank equals the slot number. Slot k can only draw from inputs k and higher, so the multiplexer for each slot is narrower than the one for the slot below it.

Top module: `nz_compactor`

## Requirements
- R1: Output slot 0 holds the value of the lowest-numbered nonzero input, or zero when every input is zero.
- R2: For each k, output slot k holds the (k+1)-th nonzero input counted upward from element 0, so the nonzero values keep their input order. Element i occupies bits [8i+7:8i] of both `in_data` and `out_data`.
- R3: Output slot 7 is nonzero only when all eight inputs are nonzero, and in that case it holds input element 7.
- R4: Every output slot whose index is at or above `out_count` holds zero.
- R5: `out_count` is an unsigned 4-bit number equal to the number of nonzero inputs, in the range 0 to 8.
- R6: `out_valid` is high in the cycle after a cycle in which `in_valid` is high, and the result of that vector is present on `out_data` and `out_count` in that same cycle.
- R7: After a cycle with `in_valid` low, `out_valid` is low, and `out_data` and `out_count` keep their previous values whatever `in_data` carries.
- R8: A synchronous, active-high `rst` clears `out_data`, `out_count` and `out_valid` to zero. Reset takes priority over `in_valid`.
- R9: When vectors arrive on consecutive cycles, each one produces its own result on consecutive cycles, with no stall and no mixing between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks `in_data` as a vector to compact |
| in_data | input | 64 | Eight 8-bit elements, element i at bits [8i+7:8i] |
| out_valid | output | 1 | High for one cycle per accepted vector |
| out_data | output | 64 | Packed vector, same element layout as `in_data` |
| out_count | output | 4 | Number of nonzero elements in the accepted vector |

## Verification
Two functions can land in the same clock edge. In one case, the register captures a new vector while the previous result is still being presented. In the other, the last slot and the count both reach their extreme when all eight inputs are nonzero. The bench provokes the first case by holding `in_valid` high for an unbroken sweep of all 256 zero/nonzero patterns. It judges every cycle against a reference model, so any result that lags, repeats or mixes with its neighbour is caught. The all-nonzero patterns within that sweep, together with a final vector that is entirely 0xFF, make the slot 7 case and the count of 8 fall into that same continuous stream.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

    parameter int NUM_EL = 8;
    parameter int EL_W   = 8;
    localparam int VEC_W = NUM_EL * EL_W;
    localparam int CNT_W = $clog2(NUM_EL + 1);

    typedef logic [VEC_W-1:0] vec_t;
    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        cnt_t count;
        vec_t data;
    } result_t;

    // True when every slot at or above cnt carries zero
    function automatic logic tail_zero_ok(input vec_t data, input cnt_t cnt);
        for (int i = 0; i < NUM_EL; i++) begin
            if (i >= int'(cnt) && data[i*EL_W +: EL_W] != '0)
                return 1'b0;
        end
        return 1'b1;
    endfunction

endpackage

// File: rtl/nz_rank.sv
module nz_rank #(
    parameter int N     = cmp_pkg::NUM_EL,
    parameter int EL_W  = cmp_pkg::EL_W,
    parameter int CNT_W = cmp_pkg::CNT_W
) (
    input  logic [N*EL_W-1:0]  elems,
    output logic [N-1:0]       flags,
    output logic [N*CNT_W-1:0] ranks,
    output logic [CNT_W-1:0]   total
);

    // Exclusive prefix count: rank of element i = nonzero flags below i
    always_comb begin
        logic [CNT_W-1:0] acc;
        acc   = '0;
        flags = '0;
        ranks = '0;
        for (int i = 0; i < N; i++) begin
            flags[i] = (elems[i*EL_W +: EL_W] != '0);
            ranks[i*CNT_W +: CNT_W] = acc;
            if (flags[i])
                acc = acc + CNT_W'(1);
        end
        total = acc;
    end

endmodule

// File: rtl/slot_select.sv
module slot_select #(
    parameter int SRC   = 8,
    parameter int SLOT  = 0,
    parameter int EL_W  = cmp_pkg::EL_W,
    parameter int CNT_W = cmp_pkg::CNT_W
) (
    input  logic [SRC*EL_W-1:0]  src_data,
    input  logic [SRC-1:0]       src_flag,
    input  logic [SRC*CNT_W-1:0] src_rank,
    output logic [EL_W-1:0]      slot_out
);

    logic [SRC-1:0] hit;

    // Source j (local index) feeds this slot when it is nonzero and
    // exactly SLOT nonzero elements sit below it
    always_comb begin
        hit = '0;
        for (int j = 0; j < SRC; j++)
            hit[j] = src_flag[j] && (src_rank[j*CNT_W +: CNT_W] == CNT_W'(SLOT));
    end

    // AND-OR multiplexer; zero when no source matches
    always_comb begin
        slot_out = '0;
        for (int j = 0; j < SRC; j++)
            slot_out = slot_out | (src_data[j*EL_W +: EL_W] & {EL_W{hit[j]}});
    end

    // R2: at most one input may claim a given destination rank
    always_comb begin
        a_single_src_r2: assert ($onehot0(hit))
            else $error("slot %0d selected more than one source", SLOT);
    end

endmodule

// File: rtl/nz_compactor.sv
module nz_compactor #(
    parameter int N     = cmp_pkg::NUM_EL,
    parameter int EL_W  = cmp_pkg::EL_W,
    parameter int CNT_W = cmp_pkg::CNT_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [N*EL_W-1:0]   in_data,
    output logic                out_valid,
    output logic [N*EL_W-1:0]   out_data,
    output logic [CNT_W-1:0]    out_count
);
    import cmp_pkg::*;

    logic [N-1:0]       flags;
    logic [N*CNT_W-1:0] ranks;
    logic [CNT_W-1:0]   total;
    logic [EL_W-1:0]    slot_val [N];
    result_t            res_d, res_q;
    logic               vld_q;

    nz_rank #(.N(N), .EL_W(EL_W), .CNT_W(CNT_W)) u_rank (
        .elems (in_data),
        .flags (flags),
        .ranks (ranks),
        .total (total)
    );

    // One selector per slot; slot k sees only inputs k..N-1
    for (genvar k = 0; k < N; k++) begin : g_slot
        localparam int SRC = N - k;
        slot_select #(.SRC(SRC), .SLOT(k), .EL_W(EL_W), .CNT_W(CNT_W)) u_sel (
            .src_data (in_data[N*EL_W-1 : k*EL_W]),
            .src_flag (flags[N-1 : k]),
            .src_rank (ranks[N*CNT_W-1 : k*CNT_W]),
            .slot_out (slot_val[k])
        );
    end

    always_comb begin
        res_d.count = total;
        res_d.data  = '0;
        for (int k = 0; k < N; k++)
            res_d.data[k*EL_W +: EL_W] = slot_val[k];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= in_valid;
            if (in_valid)
                res_q <= res_d;
        end
    end

    assign out_valid = vld_q;
    assign out_data  = res_q.data;
    assign out_count = res_q.count;

    p_valid_follow_r6: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_data) && $stable(out_count)));

    p_count_max_r5: assert property (@(posedge clk) disable iff (rst)
        out_count <= CNT_W'(N));

    p_tail_zero_r4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> tail_zero_ok(out_data, out_count));

    p_last_slot_r3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_count != CNT_W'(N)) |-> (out_data[N*EL_W-1 -: EL_W] == '0));

endmodule

// File: tb/test_nz_compactor.sv
`timescale 1ns/1ps
module test_nz_compactor;

    localparam int N = 8;
    localparam int W = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid;
    logic [63:0]   in_data;
    logic          out_valid;
    logic [63:0]   out_data;
    logic [3:0]    out_count;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    nz_compactor i_nz_compactor (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_count (out_count)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference: {count, packed vector}
    function automatic logic [67:0] model(input logic [63:0] v);
        logic [63:0] o;
        int          n;
        o = '0;
        n = 0;
        for (int i = 0; i < N; i++) begin
            if (v[i*W +: W] != 8'h00) begin
                o[n*W +: W] = v[i*W +: W];
                n++;
            end
        end
        return {4'(n), o};
    endfunction

    function automatic logic [63:0] gen(input int p);
        logic [63:0] v;
        v = '0;
        if (p < 256) begin
            for (int i = 0; i < N; i++)
                if (p[i]) v[i*W +: W] = 8'(((p * 7 + i * 29) % 255) + 1);
        end else if (p == 256) begin
            // elements 0..7 = 0,4,0,0,5,0,2,0
            v = {8'd0, 8'd2, 8'd0, 8'd5, 8'd0, 8'd0, 8'd4, 8'd0};
        end else begin
            v = {8{8'hFF}};
        end
        return v;
    endfunction

    task automatic check_result(input logic [67:0] e);
        logic [63:0] ed;
        logic [3:0]  ec;
        ed = e[63:0];
        ec = e[67:64];
        check("R6 out_valid", 64'(out_valid), 64'd1);
        check("R2 packed order", out_data, ed);
        check("R5 count", 64'(out_count), 64'(ec));
        check("R1 slot0", 64'(out_data[7:0]), 64'(ed[7:0]));
        check("R3 slot7", 64'(out_data[63:56]), (ec == 4'd8) ? 64'(ed[63:56]) : 64'd0);
        for (int k = 0; k < N; k++)
            if (k >= int'(ec))
                check("R4 tail zero", 64'(out_data[k*W +: W]), 64'd0);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [67:0] prev;
        logic        have_prev;
        rst      = 1'b1;
        in_valid = 1'b0;
        in_data  = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R8 reset valid", 64'(out_valid), 64'd0);
        check("R8 reset data", out_data, 64'd0);
        check("R8 reset count", 64'(out_count), 64'd0);
        rst = 1'b0;

        // R9: unbroken stream of vectors, one result per cycle
        have_prev = 1'b0;
        prev      = '0;
        for (int p = 0; p < 258; p++) begin
            @(negedge clk);
            if (have_prev) check_result(prev);
            in_data   = gen(p);
            in_valid  = 1'b1;
            prev      = model(gen(p));
            have_prev = 1'b1;
        end
        @(negedge clk);
        check_result(prev);

        // R7: idle cycles ignore in_data and hold the last result
        in_valid = 1'b0;
        in_data  = 64'h0102_0304_0506_0708;
        @(negedge clk);
        check("R7 valid low", 64'(out_valid), 64'd0);
        check("R7 data held", out_data, prev[63:0]);
        check("R7 count held", 64'(out_count), 64'(prev[67:64]));
        in_data = 64'h00FF_00FF_00FF_00FF;
        @(negedge clk);
        check("R7 data held", out_data, prev[63:0]);
        check("R7 count held", 64'(out_count), 64'(prev[67:64]));

        // R8: reset wins over a valid vector
        in_valid = 1'b1;
        rst      = 1'b1;
        @(negedge clk);
        check("R8 reset priority valid", 64'(out_valid), 64'd0);
        check("R8 reset priority data", out_data, 64'd0);
        check("R8 reset priority count", 64'(out_count), 64'd0);
        rst      = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule